// File: doc/BRIEF.md
# Mode-Steered Interrupt Status Controller

This block collects event pulses from an infrared serial link and turns them into one level interrupt. It keeps two banks of sticky status bits, each with its own enable mask and its own write-one-to-clear port. One bank serves the slow asynchronous mode. The other serves the framed medium and fast modes. A transfer-mode register holds a 2-bit mode code and three top-level mask bits. The mode code decides which bank an incoming event lands in.

Both banks use the same five bit positions. The meaning of two of those positions depends on the mode. In the slow bank, bit 9 is a receive timeout and bit 8 is a framing error. In the framed bank, bit 9 is an abort and bit 8 is a CRC error.

Software talks to the block over a plain 16-bit port. A write is one cycle with `we_i` high. Read data is combinational from `addr_i`. The register word addresses are listed below:

| Address | Register |
|---|---|
| 0 | transfer-mode register |
| 1 | slow bank status |
| 2 | slow bank mask |
| 3 | slow bank clear |
| 4 | framed bank status |
| 5 | framed bank mask |
| 6 | framed bank clear |

Top module: `irq_status_ctrl`

## Requirements
- R1: After reset:
  - the mode register reads 0x0111, which is mode 00 with all three top-level masks set;
  - both bank mask registers read 0x8B80;
  - both status registers read 0;
  - `irq_o` is 0.
- R2: Unused bits read as 0 and ignore writes:
  - in the mode register, only bits 15:14, 8, 4 and 0 are held;
  - in the bank registers, only bits 15, 11, 9, 8 and 7 are held;
  - address 7 and both clear addresses read 0.
- R3: Event input `evt_i[0]` sets status bit 15 (frame received). The other inputs map as follows:
  - `evt_i[1]` sets bit 11 (buffer overflow);
  - `evt_i[2]` sets bit 9 (timeout or abort);
  - `evt_i[3]` sets bit 8 (framing or CRC error);
  - `evt_i[4]` sets bit 7 (frame sent).
  - No status bit becomes set without its event.
- R4: The mode field, bits 15:14 of the mode register, decides which bank receives events:
  - 00 steers events into the slow bank;
  - 10 (fast) and 11 (medium) steer them into the framed bank;
  - 01 is reserved, and events arriving in that mode are dropped.
- R5: Status bits are sticky. A set bit stays set until software clears it.
- R6: Writing a word to a bank's clear address clears the status bits that are 1 in the word. Status bits that are 0 in the word are left unchanged.
- R7: When an event and a clear of the same bit fall in the same cycle, the bit ends up set.
- R8: A pending status bit does not contribute to the interrupt when its bank mask bit is 1.
- R9: The top-level mask bits silence a whole bank:
  - mode register bit 0 masks the slow bank;
  - bit 4 masks the framed bank;
  - bit 8, the FIFO receive mask, is stored but has no effect on `irq_o`.
- R10: `irq_o` is registered.
  - It rises one cycle after an unmasked status bit becomes visible.
  - It reflects both banks regardless of the current mode.
- R11: Writes to the status addresses have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| we_i | input | 1 | Register write strobe |
| addr_i | input | ADDR_W | Register word address |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Read data for `addr_i` (combinational) |
| evt_i | input | 5 | Event pulses: frame received, overflow, timeout/abort, framing/CRC error, frame sent |
| irq_o | output | 1 | Interrupt request |

## Verification
The bench uses the default `ADDR_W` of 3, which maps the full register space including the one spare address. With five events, four mode codes and two banks, it can sweep every event in every mode. For each bank it also sweeps every combination of per-event mask bit and top-level mask bit. Expected status words are built in the bench from a bit-position table, and interrupt levels are derived from the mask pair.

// File: rtl/isc_pkg.sv
`timescale 1ns/1ps
package isc_pkg;
  localparam int unsigned DATA_W   = 16;
  localparam int unsigned NUM_EVT  = 5;
  localparam int unsigned NUM_BANK = 2;
  localparam int unsigned BANK_SLOW   = 0;
  localparam int unsigned BANK_FRAMED = 1;

  // event index -> status bit position (shared by both banks)
  localparam int unsigned EVT_POS [NUM_EVT] = '{15, 11, 9, 8, 7};

  localparam int unsigned MODE_LSB     = 14;
  localparam int unsigned TOP_SLOW_BIT = 0;
  localparam int unsigned TOP_FR_BIT   = 4;
  localparam int unsigned TOP_FIFO_BIT = 8;

  typedef logic [DATA_W-1:0] word_t;

  typedef enum logic [1:0] {
    MODE_SLOW = 2'b00,
    MODE_RSVD = 2'b01,
    MODE_FAST = 2'b10,
    MODE_MED  = 2'b11
  } xfer_mode_e;

  function automatic word_t evt_spread(logic [NUM_EVT-1:0] evt);
    word_t w;
    w = '0;
    for (int i = 0; i < NUM_EVT; i++)
      if (evt[i]) w[EVT_POS[i]] = 1'b1;
    return w;
  endfunction

  localparam word_t EVT_LEGAL = evt_spread('1);
endpackage

// File: rtl/isc_mode_reg.sv
`timescale 1ns/1ps
module isc_mode_reg
  import isc_pkg::*;
(
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                we_i,
  input  word_t               wdata_i,
  output xfer_mode_e          mode_o,
  output logic [NUM_BANK-1:0] top_mk_o,
  output word_t               rdata_o
);
  logic [1:0] mode_q;
  logic       slow_mk_q, fr_mk_q, fifo_mk_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q    <= 2'b00;
      slow_mk_q <= 1'b1;
      fr_mk_q   <= 1'b1;
      fifo_mk_q <= 1'b1;
    end else if (we_i) begin
      mode_q    <= wdata_i[MODE_LSB +: 2];
      slow_mk_q <= wdata_i[TOP_SLOW_BIT];
      fr_mk_q   <= wdata_i[TOP_FR_BIT];
      fifo_mk_q <= wdata_i[TOP_FIFO_BIT];
    end
  end

  assign mode_o = xfer_mode_e'(mode_q);

  always_comb begin
    top_mk_o              = '0;
    top_mk_o[BANK_SLOW]   = slow_mk_q;
    top_mk_o[BANK_FRAMED] = fr_mk_q;
  end

  always_comb begin
    rdata_o                   = '0;
    rdata_o[MODE_LSB +: 2]    = mode_q;
    rdata_o[TOP_SLOW_BIT]     = slow_mk_q;
    rdata_o[TOP_FR_BIT]       = fr_mk_q;
    rdata_o[TOP_FIFO_BIT]     = fifo_mk_q;
  end
endmodule

// File: rtl/isc_evt_steer.sv
`timescale 1ns/1ps
module isc_evt_steer
  import isc_pkg::*;
(
  input  xfer_mode_e                        mode_i,
  input  logic [NUM_EVT-1:0]                evt_i,
  output logic [NUM_BANK-1:0][DATA_W-1:0]   set_o
);
  word_t spread;
  assign spread = evt_spread(evt_i);

  always_comb begin
    set_o = '0;
    unique case (mode_i)
      MODE_SLOW:           set_o[BANK_SLOW]   = spread;
      MODE_MED, MODE_FAST: set_o[BANK_FRAMED] = spread;
      default:             ; // reserved code drops events
    endcase
  end
endmodule

// File: rtl/isc_bank.sv
`timescale 1ns/1ps
module isc_bank
  import isc_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  word_t set_i,
  input  word_t clr_i,
  input  logic  mk_we_i,
  input  word_t mk_wdata_i,
  output word_t st_o,
  output word_t mk_o,
  output logic  pend_o
);
  word_t st_q, mk_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= '0;
      mk_q <= EVT_LEGAL;
    end else begin
      // set applied after clear: set wins
      st_q <= ((st_q & ~clr_i) | set_i) & EVT_LEGAL;
      if (mk_we_i) mk_q <= mk_wdata_i & EVT_LEGAL;
    end
  end

  assign st_o   = st_q;
  assign mk_o   = mk_q;
  assign pend_o = |(st_q & ~mk_q);
endmodule

// File: rtl/irq_status_ctrl.sv
`timescale 1ns/1ps
module irq_status_ctrl
  import isc_pkg::*;
#(
  parameter int unsigned ADDR_W = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic [NUM_EVT-1:0] evt_i,
  output logic              irq_o
);
  localparam int unsigned BANK_STRIDE = 3;
  localparam logic [ADDR_W-1:0] MODE_A = '0;

  xfer_mode_e                      mode_q;
  logic [NUM_BANK-1:0]             top_mk;
  word_t                           mode_rd;
  logic [NUM_BANK-1:0][DATA_W-1:0] bank_set, bank_st, bank_mk;
  logic [NUM_BANK-1:0]             bank_pend, bank_irq;
  word_t                           slow_st, fast_st, slow_mk, fast_mk;
  logic                            irq_q;

  isc_mode_reg u_mode (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .we_i     (we_i && addr_i == MODE_A),
    .wdata_i  (wdata_i),
    .mode_o   (mode_q),
    .top_mk_o (top_mk),
    .rdata_o  (mode_rd)
  );

  isc_evt_steer u_steer (
    .mode_i (mode_q),
    .evt_i  (evt_i),
    .set_o  (bank_set)
  );

  for (genvar b = 0; b < NUM_BANK; b++) begin : g_bank
    localparam logic [ADDR_W-1:0] MK_A  = ADDR_W'(2 + BANK_STRIDE * b);
    localparam logic [ADDR_W-1:0] CLR_A = ADDR_W'(3 + BANK_STRIDE * b);
    word_t clr;
    assign clr = (we_i && addr_i == CLR_A) ? wdata_i : '0;

    isc_bank u_bank (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .set_i      (bank_set[b]),
      .clr_i      (clr),
      .mk_we_i    (we_i && addr_i == MK_A),
      .mk_wdata_i (wdata_i),
      .st_o       (bank_st[b]),
      .mk_o       (bank_mk[b]),
      .pend_o     (bank_pend[b])
    );
    assign bank_irq[b] = bank_pend[b] & ~top_mk[b];
  end

  always_comb begin
    rdata_o = '0;
    if (addr_i == MODE_A) rdata_o = mode_rd;
    for (int b = 0; b < NUM_BANK; b++) begin
      if (addr_i == ADDR_W'(1 + BANK_STRIDE * b)) rdata_o = bank_st[b];
      if (addr_i == ADDR_W'(2 + BANK_STRIDE * b)) rdata_o = bank_mk[b];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_q <= 1'b0;
    else         irq_q <= |bank_irq;
  end

  assign irq_o   = irq_q;
  assign slow_st = bank_st[BANK_SLOW];
  assign fast_st = bank_st[BANK_FRAMED];
  assign slow_mk = bank_mk[BANK_SLOW];
  assign fast_mk = bank_mk[BANK_FRAMED];
endmodule

// File: rtl/irq_status_ctrl_chk.sv
`timescale 1ns/1ps
module irq_status_ctrl_chk
  import isc_pkg::*;
#(
  parameter int unsigned ADDR_W = 3
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               we_i,
  input logic [ADDR_W-1:0]  addr_i,
  input logic [NUM_EVT-1:0] evt_i,
  input logic               irq_o,
  input logic [DATA_W-1:0]  slow_st,
  input logic [DATA_W-1:0]  fast_st,
  input logic [DATA_W-1:0]  slow_mk,
  input logic [DATA_W-1:0]  fast_mk,
  input logic [1:0]         mode_q,
  input logic [NUM_BANK-1:0] top_mk
);
  localparam logic [ADDR_W-1:0] SLOW_CLR_A = ADDR_W'(3);

  AST_NO_SPONTANEOUS_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_i == '0 |=> ((slow_st & ~$past(slow_st)) == '0) && ((fast_st & ~$past(fast_st)) == '0)); // R3

  AST_RSVD_MODE_DROPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q == 2'b01 && !we_i) |=> $stable(slow_st) && $stable(fast_st)); // R4

  AST_SLOW_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(we_i && addr_i == SLOW_CLR_A) |=> (slow_st & $past(slow_st)) == $past(slow_st)); // R5

  AST_SET_BEATS_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q == 2'b00 && evt_i[0] && we_i && addr_i == SLOW_CLR_A) |=> slow_st[15]); // R7

  AST_ALL_MASKED_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (slow_mk == EVT_LEGAL && fast_mk == EVT_LEGAL) |=> !irq_o); // R8

  AST_IRQ_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> irq_o == $past(((|(slow_st & ~slow_mk)) && !top_mk[0]) ||
                            ((|(fast_st & ~fast_mk)) && !top_mk[1]))); // R10
endmodule

bind irq_status_ctrl irq_status_ctrl_chk #(.ADDR_W(ADDR_W)) i_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .we_i    (we_i),
  .addr_i  (addr_i),
  .evt_i   (evt_i),
  .irq_o   (irq_o),
  .slow_st (slow_st),
  .fast_st (fast_st),
  .slow_mk (slow_mk),
  .fast_mk (fast_mk),
  .mode_q  (mode_q),
  .top_mk  (top_mk)
);

// File: tb/test_irq_status_ctrl.sv
`timescale 1ns/1ps
module test_irq_status_ctrl;
  localparam int AW = 3;
  localparam logic [15:0] LEGAL = 16'h8B80;
  int pos [5] = '{15, 11, 9, 8, 7};

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          we = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [15:0]   wdata = '0;
  logic [15:0]   rdata;
  logic [4:0]    evt = '0;
  logic          irq;
  int            n_chk = 0;
  int            n_bad = 0;

  always #2.5 clk = ~clk;

  irq_status_ctrl #(.ADDR_W(AW)) i_irq_status_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .we_i(we), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rdata), .evt_i(evt), .irq_o(irq)
  );

  task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%04h expected 0x%04h", req, act, exp);
    end
  endtask

  task automatic wr(int a, logic [15:0] d);
    @(negedge clk); we = 1'b1; addr = a[AW-1:0]; wdata = d;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic rd(int a, output logic [15:0] d);
    addr = a[AW-1:0]; #1; d = rdata;
  endtask

  task automatic pulse(int e);
    @(negedge clk); evt = 5'(1 << e);
    @(negedge clk); evt = '0;
  endtask

  task automatic clr_all();
    wr(3, 16'hFFFF); wr(6, 16'hFFFF);
  endtask

  initial begin
    repeat (60000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [15:0] v, v2, m;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    rd(0, v); chk("R1 mode", v, 16'h0111);
    rd(1, v); chk("R1 slow st", v, 0);
    rd(2, v); chk("R1 slow mk", v, LEGAL);
    rd(4, v); chk("R1 fast st", v, 0);
    rd(5, v); chk("R1 fast mk", v, LEGAL);
    chk("R1 irq", {15'b0, irq}, 0);

    // R2 unused bits
    wr(0, 16'hFFFF); rd(0, v); chk("R2 mode bits", v, 16'hC111);
    wr(2, 16'hFFFF); rd(2, v); chk("R2 mask bits", v, LEGAL);
    wr(5, 16'h0000); rd(5, v); chk("R2 mask clear", v, 0);
    rd(7, v); chk("R2 spare addr", v, 0);
    rd(3, v); chk("R2 clear reads", v, 0);
    wr(5, LEGAL); wr(0, 16'h0111);

    // R3 R4 R5: every event in every mode, all masked (R8)
    for (int md = 0; md < 4; md++) begin
      wr(0, 16'((md << 14) | 16'h0111));
      for (int e = 0; e < 5; e++) begin
        clr_all();
        pulse(e);
        repeat (2) @(negedge clk);
        rd(1, v); rd(4, v2);
        chk("R3 R4 slow bank", v,  (md == 0) ? 16'(1 << pos[e]) : 16'h0);
        chk("R4 R5 framed bank", v2, (md >= 2) ? 16'(1 << pos[e]) : 16'h0);
        chk("R8 masked irq", {15'b0, irq}, 0);
      end
    end

    // R6 write-one-to-clear, R11 status writes ignored
    wr(0, 16'h0111); clr_all();
    pulse(0); pulse(4);
    rd(1, v); chk("R5 two events", v, 16'h8080);
    wr(3, 16'h0080); rd(1, v); chk("R6 partial clear", v, 16'h8000);
    wr(3, 16'h8000); rd(1, v); chk("R6 full clear", v, 0);
    pulse(1);
    wr(1, 16'hFFFF); rd(1, v); chk("R11 status write ones", v, 16'h0800);
    wr(1, 16'h0000); rd(1, v); chk("R11 status write zero", v, 16'h0800);
    clr_all();

    // R7 set beats clear in same cycle
    @(negedge clk); evt = 5'b00001; we = 1'b1; addr = 3'd3; wdata = 16'h8000;
    @(negedge clk); evt = '0; we = 1'b0;
    rd(1, v); chk("R7 set wins", v, 16'h8000);
    clr_all();

    // R8 R9 R10 mask sweep per bank
    for (int bk = 0; bk < 2; bk++) begin
      for (int e = 0; e < 5; e++) begin
        for (int b = 0; b < 2; b++) begin
          for (int t = 0; t < 2; t++) begin
            m = (b != 0) ? LEGAL : (LEGAL & ~16'(1 << pos[e]));
            wr(bk ? 5 : 2, m);
            if (bk == 0) wr(0, 16'(16'h0110 | t));
            else         wr(0, 16'(16'hC101 | (t << 4)));
            clr_all();
            pulse(e);
            chk("R10 irq latency", {15'b0, irq}, 0);
            @(negedge clk);
            chk("R8 R9 irq", {15'b0, irq}, {15'b0, (b == 0 && t == 0)});
          end
        end
      end
      wr(bk ? 5 : 2, LEGAL);
    end

    // R10 pending bank outside current mode still drives irq; R9 fifo bit inert
    clr_all();
    wr(2, 16'h0000); wr(0, 16'h0110);
    pulse(2);
    @(negedge clk);
    chk("R9 fifo mask inert", {15'b0, irq}, 1);
    wr(0, 16'h8110);
    @(negedge clk);
    chk("R10 other bank irq", {15'b0, irq}, 1);
    wr(3, 16'hFFFF);
    @(negedge clk);
    chk("R6 irq drops after clear", {15'b0, irq}, 0);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule